// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a virtual page number into a physical frame number. It walks an inverted page table held in memory. That table has exactly one entry per physical frame, so its size follows installed memory and not the virtual address width. A request carries a page number and an address-space identifier. The walker folds the page number into a short index and reads a slot of an anchor table at a fixed base address. The slot holds a pointer to the first entry of a collision chain. The walker then reads entries along that chain until the stored tag equals the request or the chain runs out.

The walker handles one translation at a time. It sits behind a memory read port that accepts a one-cycle request pulse and later returns a single data word with a valid strobe. The frame number it returns is the position of the matching entry inside the inverted table. A programmable limit on chain length protects against a corrupted link that closes a cycle. When that limit trips, the result is a fault with a separate error flag, and the walker goes back to idle.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready_o` is high, and `done_o` and `mem_req_o` are low.
- R2: The first read of every walk goes to `ANCHOR_BASE` plus a hash index. The hash splits the page number into `IDX_W`-bit chunks, starting at the least significant bits, zero-pads the top chunk, and XORs all chunks together.
- R3: A word read from the anchor table carries its pointer in bits `[ADDR_W-1:0]`. When that pointer is not null, the next read goes to that pointer. An entry word is laid out, from MSB to LSB, as {asid, vpn, next_ptr}, with next_ptr in bits `[ADDR_W-1:0]`.
- R4: A hit requires both the stored ASID and the stored VPN to equal the request. On a hit, `pfn_o` is the low `FRAME_W` bits of (entry address − `TABLE_BASE`).
- R5: A hit on the first entry of a chain takes exactly two memory reads.
- R6: On a tag mismatch, the walker reads the entry that the link points to. A link equal to the null value (all ones) ends the walk with `fault_o` high and `loop_err_o` low.
- R7: A null anchor slot ends the walk after one read, with a fault and no loop error.
- R8: A walk reads at most max(1, `max_chain_i`) entries. The limit is sampled when the request is accepted. If the last allowed entry mismatches and its link is not null, the result is a fault with `loop_err_o` high.
- R9: `done_o` is high for exactly one cycle per request, with exactly one of `hit_o` and `fault_o` set. The result outputs hold until the next request is accepted. The cycle after `done_o`, `req_ready_o` is high again.
- R10: `mem_req_o` is a single-cycle pulse, and no new read is issued until the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle; a request is accepted this cycle |
| req_vpn_i | input | VPN_W | Virtual page number to translate |
| req_asid_i | input | ASID_W | Address-space identifier of the request |
| max_chain_i | input | CNT_W | Maximum number of entries read per walk |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | ADDR_W | Word address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | ASID_W+VPN_W+ADDR_W | Read data word |
| done_o | output | 1 | Result valid for one cycle |
| hit_o | output | 1 | Translation found |
| fault_o | output | 1 | Page fault |
| loop_err_o | output | 1 | Fault caused by the chain length limit |
| pfn_o | output | FRAME_W | Physical frame number on a hit |

## Verification
Each walk's internal state shows up as the sequence of addresses it issues. A wrong hash or a wrong stored pointer therefore produces a bad address at the first or second read, and the bench compares both against a software walk of the same table. A chain counter that counts wrong or latches the limit wrong changes the number of reads and flips `loop_err_o` on the walks built to stop exactly at, or one entry short of, the limit. These errors are visible at the `done_o` pulse of the affected request. A result register that is not held, or a walker that does not return to idle, is caught in the cycle right after `done_o`.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ANC_REQ,
    ST_ANC_WAIT,
    ST_ENT_REQ,
    ST_ENT_WAIT,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 20,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NCHUNK = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] part [NCHUNK];

  assign padded = PAD_W'(vpn_i);

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign part[g] = padded[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NCHUNK; i++) idx_o = idx_o ^ part[i];
  end
endmodule

// File: rtl/ipt_entry_match.sv
module ipt_entry_match #(
  parameter int          VPN_W      = 20,
  parameter int          ASID_W     = 4,
  parameter int          ADDR_W     = 16,
  parameter int          FRAME_W    = 8,
  parameter logic [15:0] TABLE_BASE = 16'h0100
) (
  input  logic [ASID_W+VPN_W+ADDR_W-1:0] entry_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [VPN_W-1:0]               vpn_i,
  input  logic [ASID_W-1:0]              asid_i,
  output logic                           match_o,
  output logic [ADDR_W-1:0]              next_o,
  output logic                           next_null_o,
  output logic [FRAME_W-1:0]             pfn_o
);
  logic [ASID_W-1:0] e_asid;
  logic [VPN_W-1:0]  e_vpn;
  logic [ADDR_W-1:0] offset;

  assign {e_asid, e_vpn, next_o} = entry_i;
  assign match_o     = (e_asid == asid_i) && (e_vpn == vpn_i);
  assign next_null_o = &next_o;
  assign offset      = addr_i - ADDR_W'(TABLE_BASE);
  assign pfn_o       = offset[FRAME_W-1:0];
endmodule

// File: rtl/ipt_chain_guard.sv
module ipt_chain_guard #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             step_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      max_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      max_q <= max_i;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // entry under evaluation is number cnt_q+1
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, max_q};

  // R8
  chain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= max_q) || (cnt_q <= 1));
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int          VPN_W       = 20,
  parameter int          ASID_W      = 4,
  parameter int          IDX_W       = 4,
  parameter int          ADDR_W      = 16,
  parameter int          FRAME_W     = 8,
  parameter int          CNT_W       = 8,
  parameter logic [15:0] ANCHOR_BASE = 16'h0010,
  parameter logic [15:0] TABLE_BASE  = 16'h0100
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [VPN_W-1:0]               req_vpn_i,
  input  logic [ASID_W-1:0]              req_asid_i,
  input  logic [CNT_W-1:0]               max_chain_i,
  output logic                           mem_req_o,
  output logic [ADDR_W-1:0]              mem_addr_o,
  input  logic                           mem_rvalid_i,
  input  logic [ASID_W+VPN_W+ADDR_W-1:0] mem_rdata_i,
  output logic                           done_o,
  output logic                           hit_o,
  output logic                           fault_o,
  output logic                           loop_err_o,
  output logic [FRAME_W-1:0]             pfn_o
);
  localparam logic [ADDR_W-1:0] NULL_PTR = '1;

  walk_state_e       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              hit_q, fault_q, loop_q;
  logic [FRAME_W-1:0] pfn_q;

  logic [IDX_W-1:0]   idx;
  logic [ADDR_W-1:0]  anc_ptr, next_ptr;
  logic               ent_match, next_null, chain_last;
  logic [FRAME_W-1:0] ent_pfn;
  logic               accept, step;

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign step    = (state_q == ST_ENT_WAIT) && mem_rvalid_i;
  assign anc_ptr = mem_rdata_i[ADDR_W-1:0];

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn_i (vpn_q),
    .idx_o (idx)
  );

  ipt_entry_match #(
    .VPN_W(VPN_W), .ASID_W(ASID_W), .ADDR_W(ADDR_W),
    .FRAME_W(FRAME_W), .TABLE_BASE(TABLE_BASE)
  ) u_match (
    .entry_i     (mem_rdata_i),
    .addr_i      (ptr_q),
    .vpn_i       (vpn_q),
    .asid_i      (asid_q),
    .match_o     (ent_match),
    .next_o      (next_ptr),
    .next_null_o (next_null),
    .pfn_o       (ent_pfn)
  );

  ipt_chain_guard #(.CNT_W(CNT_W)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .max_i   (max_chain_i),
    .step_i  (step),
    .last_o  (chain_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      asid_q  <= '0;
      ptr_q   <= '0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      loop_q  <= 1'b0;
      pfn_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vpn_i;
          asid_q  <= req_asid_i;
          hit_q   <= 1'b0;
          fault_q <= 1'b0;
          loop_q  <= 1'b0;
          pfn_q   <= '0;
          state_q <= ST_ANC_REQ;
        end
        ST_ANC_REQ: state_q <= ST_ANC_WAIT;
        ST_ANC_WAIT: if (mem_rvalid_i) begin
          if (anc_ptr == NULL_PTR) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            ptr_q   <= anc_ptr;
            state_q <= ST_ENT_REQ;
          end
        end
        ST_ENT_REQ: state_q <= ST_ENT_WAIT;
        ST_ENT_WAIT: if (mem_rvalid_i) begin
          if (ent_match) begin
            hit_q   <= 1'b1;
            pfn_q   <= ent_pfn;
            state_q <= ST_DONE;
          end else if (next_null) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (chain_last) begin
            fault_q <= 1'b1;
            loop_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            ptr_q   <= next_ptr;
            state_q <= ST_ENT_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_ANC_REQ) || (state_q == ST_ENT_REQ);
  assign mem_addr_o  = (state_q == ST_ANC_REQ) ? ADDR_W'(ANCHOR_BASE) + ADDR_W'(idx) : ptr_q;
  assign done_o      = (state_q == ST_DONE);
  assign hit_o       = hit_q;
  assign fault_o     = fault_q;
  assign loop_err_o  = loop_q;
  assign pfn_o       = pfn_q;

  // R10
  mem_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R2
  anchor_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_req_o);

  // R9
  done_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({hit_o, fault_o}) == 1));

  // R9
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (req_ready_o && !done_o));

  // R8
  loop_is_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_err_o |-> fault_o);
endmodule

// File: tb/ipt_walker_bench.sv
`timescale 1ns/1ps
module ipt_walker_bench;
  localparam int VPN_W = 20, ASID_W = 4, ADDR_W = 16, FRAME_W = 8, CNT_W = 8;
  localparam int DATA_W = ASID_W + VPN_W + ADDR_W;
  localparam logic [15:0] ABASE = 16'h0010, TBASE = 16'h0100, NULLP = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [CNT_W-1:0] max_chain = '0;
  logic mem_req, mem_rvalid;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic done, hit, fault, loop_err;
  logic [FRAME_W-1:0] pfn;

  always #2.5 clk = ~clk;

  ipt_walker u_ipt_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vpn_i(req_vpn), .req_asid_i(req_asid), .max_chain_i(max_chain),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .hit_o(hit), .fault_o(fault), .loop_err_o(loop_err), .pfn_o(pfn)
  );

  logic [15:0] anc [16];
  logic [3:0]  t_asid [256];
  logic [19:0] t_vpn [256];
  logic [15:0] t_next [256];

  int checks = 0, fails = 0;

  function automatic logic [DATA_W-1:0] mem_word(input logic [15:0] a);
    if (a >= ABASE && a < ABASE + 16) return {24'h0, anc[a - ABASE]};
    if (a >= TBASE && a < TBASE + 256) return {t_asid[a - TBASE], t_vpn[a - TBASE], t_next[a - TBASE]};
    return '0;
  endfunction

  // memory model: one-word reads, 1..3 cycle latency
  logic busy;
  logic [15:0] paddr;
  int lat, tot, proto_err;
  logic [15:0] addr_log [1024];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      paddr <= '0; lat <= 0; tot <= 0; proto_err <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (busy) begin
        if (lat == 0) begin
          mem_rvalid <= 1'b1; mem_rdata <= mem_word(paddr); busy <= 1'b0;
        end else lat <= lat - 1;
      end
      if (mem_req) begin
        if (busy) proto_err <= proto_err + 1;
        busy <= 1'b1; paddr <= mem_addr; lat <= int'($urandom % 3);
        addr_log[tot & 1023] <= mem_addr; tot <= tot + 1;
      end
    end
  end

  function automatic logic [3:0] bhash(input logic [19:0] v);
    logic [3:0] h = '0;
    for (int i = 0; i < 20; i++) h[i % 4] = h[i % 4] ^ v[i];
    return h;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_tables();
    for (int i = 0; i < 16; i++) anc[i] = NULLP;
    for (int i = 0; i < 256; i++) begin t_asid[i] = '0; t_vpn[i] = '0; t_next[i] = NULLP; end
  endtask

  task automatic lookup(input logic [19:0] v, input logic [3:0] s, input logic [7:0] mx);
    bit e_hit = 0, e_fault = 0, e_loop = 0;
    int e_pfn = 0, e_reads = 1, n = 0, lim, t0, w = 0;
    logic [15:0] ptr, p2;
    logic h_hold;
    lim = (mx == 0) ? 1 : int'(mx);
    ptr = anc[bhash(v)];
    p2 = ptr;
    if (ptr == NULLP) e_fault = 1;
    else begin
      for (int k = 0; k < 300; k++) begin
        e_reads++; n++;
        if (t_asid[ptr - TBASE] == s && t_vpn[ptr - TBASE] == v) begin
          e_hit = 1; e_pfn = int'(ptr - TBASE); break;
        end else if (t_next[ptr - TBASE] == NULLP) begin
          e_fault = 1; break;
        end else if (n >= lim) begin
          e_fault = 1; e_loop = 1; break;
        end
        ptr = t_next[ptr - TBASE];
      end
    end
    t0 = tot;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_asid = s; max_chain = mx;
    @(negedge clk);
    req_valid = 1'b0; max_chain = 8'd1; // R8 limit sampled at accept only
    while (!done && w < 2000) begin @(negedge clk); w++; end
    check(done, "R9 done timeout", 0, 1);
    check(hit == e_hit, "R4 hit", hit, e_hit);
    check(fault == e_fault, "R6 fault", fault, e_fault);
    check(loop_err == e_loop, "R8 loop_err", loop_err, e_loop);
    if (e_hit) check(pfn == e_pfn[7:0], "R4 pfn", pfn, e_pfn);
    check(tot - t0 == e_reads, "R5 read count", tot - t0, e_reads);
    check(addr_log[t0 & 1023] == ABASE + bhash(v), "R2 anchor addr", addr_log[t0 & 1023], ABASE + bhash(v));
    if (e_reads >= 2) check(addr_log[(t0 + 1) & 1023] == p2, "R3 entry addr", addr_log[(t0 + 1) & 1023], p2);
    h_hold = hit;
    @(negedge clk);
    check(!done && req_ready && hit == h_hold, "R9 pulse/hold/ready", {done, req_ready, hit}, {1'b0, 1'b1, h_hold});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    clear_tables();
    repeat (3) @(negedge clk);
    // R1
    check(req_ready && !done && !mem_req, "R1 reset state", {req_ready, done, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !mem_req, "R1 after release", {req_ready, done, mem_req}, 3'b100);

    // random table: prepend each frame to its chain
    for (int k = 0; k < 200; k++) begin
      logic [19:0] v = 20'($urandom);
      t_vpn[k] = v; t_asid[k] = 4'($urandom); t_next[k] = anc[bhash(v)];
      anc[bhash(v)] = TBASE + 16'(k);
    end
    for (int i = 0; i < 120; i++) begin
      int k = int'($urandom % 200);
      if ($urandom % 2) lookup(t_vpn[k], t_asid[k], 8'd32);
      else lookup(20'($urandom), 4'($urandom), 8'd32);
    end
    for (int i = 0; i < 40; i++) begin
      int k = int'($urandom % 200);
      lookup(t_vpn[k], t_asid[k], 8'($urandom % 6));
    end

    // directed corners
    clear_tables();
    lookup(20'h00003, 4'd0, 8'd8);                 // R7 empty anchor
    anc[5] = TBASE + 16'd10;
    t_asid[10] = 4'd1; t_vpn[10] = 20'h00005; t_next[10] = TBASE + 16'd11;
    t_asid[11] = 4'd1; t_vpn[11] = 20'h11005; t_next[11] = TBASE + 16'd12;
    t_asid[12] = 4'd2; t_vpn[12] = 20'h22005; t_next[12] = NULLP;
    lookup(20'h00005, 4'd1, 8'd8);                 // R5 first-entry hit
    check(pfn == 8'd10, "R5 head pfn", pfn, 10);
    lookup(20'h00005, 4'd2, 8'd8);                 // R4 asid mismatch -> R6 end of chain
    lookup(20'h22005, 4'd2, 8'd3);                 // hit at exact limit
    lookup(20'h22005, 4'd2, 8'd2);                 // R8 one short of limit
    lookup(20'h22005, 4'd2, 8'd0);                 // R8 zero treated as one
    anc[7] = TBASE + 16'd20;
    t_asid[20] = 4'd0; t_vpn[20] = 20'h00007; t_next[20] = TBASE + 16'd20;
    lookup(20'h33007, 4'd0, 8'd5);                 // R8 self loop
    check(loop_err && fault, "R8 self loop flags", {loop_err, fault}, 3);

    // R10
    check(proto_err == 0, "R10 single outstanding read", proto_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule